// File: doc/BRIEF.md
# Sequential Radix-2 Signed/Unsigned Multiplier

This block multiplies two 32-bit operands over 32 clock cycles and returns a 64-bit product as an upper word and a lower word. Its datapath has one adder/subtractor that is one bit wider than an operand, a register for the multiplicand, and a single 64-bit register that holds the partial product. The multiplier operand is placed in the lower half of that register at the start and is shifted out one bit per step while product bits shift in. No separate multiplier register exists.

A one-cycle start request, seen while the unit is idle, captures both operands and a mode bit. In unsigned mode each step tests the lowest product bit and, if it is set, adds the multiplicand to the upper half. The carry of that sum becomes the new top bit when the register shifts right. In signed mode each step looks at the lowest product bit together with a stored copy of the bit that was shifted out on the previous step, and recodes the pair into add, subtract or nothing (radix-2 Booth recoding). The register then shifts right arithmetically. The result stays on the outputs until the next accepted start.

Top module: `mul_seq_top`

## Requirements
- R1: While reset is held low, busy_o and done_o are 0 and hi_o and lo_o are all zeros.
- R2: A start_i seen high at a clock edge while busy_o is low is accepted. From the next cycle on, busy_o is 1, hi_o is zero and lo_o equals the captured mplier_i.
- R3: done_o rises on the 32nd clock edge after the accepting edge. busy_o falls on that same edge.
- R4: With signed_i = 0 at acceptance, {hi_o, lo_o} at done equals the unsigned 64-bit product of the two operands. This includes 0xFFFFFFFF x 0xFFFFFFFF.
- R5: With signed_i = 1 at acceptance, {hi_o, lo_o} at done equals the two's-complement product. This includes 2 x -3 = -6 and the most negative value times itself (0x80000000 x 0x80000000 = 0x4000000000000000).
- R6: While busy_o is high, start_i, signed_i and the operand inputs are ignored. The result and the done timing are unchanged.
- R7: While busy_o is low and no start is accepted, hi_o and lo_o keep their values.
- R8: done_o is high for exactly one cycle per operation and is never high together with busy_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, taken only when idle |
| signed_i | input | 1 | 1 = two's-complement (Booth) mode, 0 = unsigned |
| mcand_i | input | 32 | Multiplicand |
| mplier_i | input | 32 | Multiplier |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse when the product is final |
| hi_o | output | 32 | Upper half of the product register |
| lo_o | output | 32 | Lower half of the product register |

## Verification
The product register is visible at the ports on every cycle, so an error in the recoding or the adder shows up as a wrong product no later than the done pulse. Errors in the arithmetic-shift sign bit or in the unsigned carry bit show up only for operands that drive the upper half negative or past 32 bits. For that reason the vectors include the most negative signed operand and all-ones unsigned operands. A counter fault moves the done edge away from cycle 32, which is seen at once. A fault in the stored previous bit corrupts only signed products whose multiplier contains runs of ones.

// File: rtl/mul_seq_pkg.sv
package mul_seq_pkg;
  typedef enum logic [1:0] {
    STEP_NOP = 2'd0,
    STEP_ADD = 2'd1,
    STEP_SUB = 2'd2
  } step_op_e;
endpackage

// File: rtl/mul_seq_recode.sv
// Chooses the arithmetic action of one iteration from the lowest product bit.
module mul_seq_recode
  import mul_seq_pkg::*;
(
  input  logic     booth_i,
  input  logic     cur_bit_i,
  input  logic     prev_bit_i,
  output step_op_e op_o
);
  always_comb begin
    op_o = STEP_NOP;
    if (booth_i) begin
      unique case ({cur_bit_i, prev_bit_i})
        2'b10:   op_o = STEP_SUB;
        2'b01:   op_o = STEP_ADD;
        default: op_o = STEP_NOP;
      endcase
    end else if (cur_bit_i) begin
      op_o = STEP_ADD;
    end
  end
endmodule

// File: rtl/mul_seq_step.sv
// One iteration: optional add/subtract into the upper half, then a right shift.
// The accumulator is one bit wider than an operand. The extra bit is a sign copy
// in signed mode and a carry in unsigned mode, and it becomes the new top bit.
module mul_seq_step
  import mul_seq_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         booth_i,
  input  step_op_e     op_i,
  input  logic [W-1:0] mcand_i,
  input  logic [W-1:0] hi_i,
  input  logic [W-1:0] lo_i,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o,
  output logic         prev_o
);
  localparam int AW = W + 1;

  logic [AW-1:0] acc_a;
  logic [AW-1:0] acc_b;
  logic [AW-1:0] acc_s;
  logic          sub;

  always_comb begin
    acc_a = {booth_i & hi_i[W-1], hi_i};
    sub   = (op_i == STEP_SUB);
    acc_b = '0;
    if (op_i != STEP_NOP) begin
      acc_b = {booth_i & mcand_i[W-1], mcand_i} ^ {AW{sub}};
    end
    acc_s  = acc_a + acc_b + AW'(sub);
    hi_o   = acc_s[AW-1:1];
    lo_o   = {acc_s[0], lo_i[W-1:1]};
    prev_o = lo_i[0];
  end
endmodule

// File: rtl/mul_seq_ctrl.sv
// Iteration counter and busy/done sequencing.
module mul_seq_ctrl #(
  parameter int STEPS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(STEPS + 1);
  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

  logic          busy_q, busy_d;
  logic          done_q, done_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          accept;

  always_comb begin
    accept = start_i & ~busy_q;
    busy_d = busy_q;
    done_d = 1'b0;
    cnt_d  = cnt_q;
    if (accept) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (busy_q) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      if (accept || busy_q) begin
        cnt_q <= cnt_d;
      end
    end
  end

  assign load_o = accept;
  assign step_o = busy_q;
  assign busy_o = busy_q;
  assign done_o = done_q;
endmodule

// File: rtl/mul_seq_top.sv
module mul_seq_top
  import mul_seq_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         signed_i,
  input  logic [W-1:0] mcand_i,
  input  logic [W-1:0] mplier_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o
);
  // Reset is asserted asynchronously and released through two flops.
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic         load, step;
  logic         booth_q;
  logic         prev_q, prev_d;
  logic [W-1:0] mcand_q;
  logic [W-1:0] hi_q, hi_d, lo_q, lo_d;
  logic [W-1:0] hi_s, lo_s;
  logic         prev_s;
  step_op_e     op;

  mul_seq_ctrl #(.STEPS(W)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .start_i(start_i),
    .load_o (load),
    .step_o (step),
    .busy_o (busy_o),
    .done_o (done_o)
  );

  mul_seq_recode u_recode (
    .booth_i   (booth_q),
    .cur_bit_i (lo_q[0]),
    .prev_bit_i(prev_q),
    .op_o      (op)
  );

  mul_seq_step #(.W(W)) u_step (
    .booth_i(booth_q),
    .op_i   (op),
    .mcand_i(mcand_q),
    .hi_i   (hi_q),
    .lo_i   (lo_q),
    .hi_o   (hi_s),
    .lo_o   (lo_s),
    .prev_o (prev_s)
  );

  always_comb begin
    hi_d   = hi_q;
    lo_d   = lo_q;
    prev_d = prev_q;
    if (load) begin
      hi_d   = '0;
      lo_d   = mplier_i;
      prev_d = 1'b0;
    end else if (step) begin
      hi_d   = hi_s;
      lo_d   = lo_s;
      prev_d = prev_s;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mcand_q <= '0;
      booth_q <= 1'b0;
    end else if (load) begin
      mcand_q <= mcand_i;
      booth_q <= signed_i;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      hi_q   <= '0;
      lo_q   <= '0;
      prev_q <= 1'b0;
    end else if (load || step) begin
      hi_q   <= hi_d;
      lo_q   <= lo_d;
      prev_q <= prev_d;
    end
  end

  assign hi_o = hi_q;
  assign lo_o = lo_q;
endmodule

// File: rtl/mul_seq_chk.sv
module mul_seq_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start_i,
  input logic         signed_i,
  input logic [W-1:0] mcand_i,
  input logic [W-1:0] mplier_i,
  input logic         busy_o,
  input logic         done_o,
  input logic [W-1:0] hi_o,
  input logic [W-1:0] lo_o
);
  localparam int CW = $clog2(W + 1) + 1;

  logic [CW-1:0]  run_q;
  logic [W-1:0]   a_q, b_q;
  logic           s_q;
  logic [2*W-1:0] ref_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      a_q   <= '0;
      b_q   <= '0;
      s_q   <= 1'b0;
    end else if (start_i && !busy_o) begin
      run_q <= '0;
      a_q   <= mcand_i;
      b_q   <= mplier_i;
      s_q   <= signed_i;
    end else if (busy_o) begin
      run_q <= run_q + 1'b1;
    end
  end

  always_comb begin
    if (s_q) ref_w = {{W{a_q[W-1]}}, a_q} * {{W{b_q[W-1]}}, b_q};
    else     ref_w = {{W{1'b0}}, a_q} * {{W{1'b0}}, b_q};
  end

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (busy_o && hi_o == '0 && lo_o == $past(mplier_i)));

  p_done_time_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (run_q == CW'(W)));

  p_unsigned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !s_q) |-> ({hi_o, lo_o} == ref_w));

  p_signed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && s_q) |-> ({hi_o, lo_o} == ref_w));

  p_busy_runs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (busy_o || done_o));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> ($stable(hi_o) && $stable(lo_o)));

  p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  p_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

bind mul_seq_top mul_seq_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .start_i (start_i),
  .signed_i(signed_i),
  .mcand_i (mcand_i),
  .mplier_i(mplier_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .hi_o    (hi_o),
  .lo_o    (lo_o)
);

// File: tb/mul_seq_top_tb.sv
module mul_seq_top_tb;
  localparam int W = 32;
  localparam int NVEC = 12;
  // Each entry: {signed mode, multiplicand, multiplier}
  localparam logic [2*W:0] VEC [NVEC] = '{
    {1'b1, 32'd2,          32'hFFFF_FFFD},
    {1'b1, 32'd2,          32'd7},
    {1'b1, 32'h8000_0000,  32'h8000_0000},
    {1'b0, 32'h8000_0000,  32'h8000_0000},
    {1'b0, 32'hFFFF_FFFF,  32'hFFFF_FFFF},
    {1'b1, 32'hFFFF_FFFF,  32'hFFFF_FFFF},
    {1'b1, 32'h7FFF_FFFF,  32'h8000_0000},
    {1'b1, 32'h8000_0000,  32'h7FFF_FFFF},
    {1'b0, 32'd0,          32'hDEAD_BEEF},
    {1'b1, 32'h1234_5678,  32'd0},
    {1'b0, 32'h0001_0000,  32'h0001_0000},
    {1'b1, 32'hFFFF_FFF0,  32'h5555_5555}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic         signed_i = 1'b0;
  logic [W-1:0] mcand_i = '0;
  logic [W-1:0] mplier_i = '0;
  logic         busy_o, done_o;
  logic [W-1:0] hi_o, lo_o;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  mul_seq_top #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .signed_i(signed_i),
    .mcand_i(mcand_i), .mplier_i(mplier_i),
    .busy_o(busy_o), .done_o(done_o), .hi_o(hi_o), .lo_o(lo_o)
  );

  function automatic logic [2*W-1:0] ref_mul(logic s, logic [W-1:0] a, logic [W-1:0] b);
    logic [2*W-1:0] ea, eb;
    ea = s ? {{W{a[W-1]}}, a} : {{W{1'b0}}, a};
    eb = s ? {{W{b[W-1]}}, b} : {{W{1'b0}}, b};
    return ea * eb;
  endfunction

  task automatic check(string req, logic [2*W-1:0] act, logic [2*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Runs one operation. With disturb set, a new start, other operands and the
  // opposite mode are presented halfway through.
  task automatic run(logic s, logic [W-1:0] a, logic [W-1:0] b, bit disturb);
    logic [2*W-1:0] exp;
    exp = ref_mul(s, a, b);
    @(negedge clk);
    start_i = 1'b1; signed_i = s; mcand_i = a; mplier_i = b;
    @(negedge clk);
    start_i = 1'b0;
    check("R2 busy after start", 64'(busy_o), 64'd1);
    check("R2 preload", {hi_o, lo_o}, {{W{1'b0}}, b});
    for (int k = 1; k < W; k++) begin
      if (disturb && k == W/2) begin
        start_i = 1'b1; signed_i = ~s; mcand_i = ~a; mplier_i = b ^ 32'h0F0F_0F0F;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
      if (done_o) check(disturb ? "R6 early done" : "R3 early done", 64'(done_o), 64'd0);
    end
    start_i = 1'b0;
    @(negedge clk);
    check("R3 done at step 32", {62'd0, done_o, busy_o}, 64'b10);
    if (disturb) check("R6 result unchanged", {hi_o, lo_o}, exp);
    else if (s)  check("R5 signed product", {hi_o, lo_o}, exp);
    else         check("R4 unsigned product", {hi_o, lo_o}, exp);
    @(negedge clk);
    check("R8 done single pulse", 64'(done_o), 64'd0);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [2*W-1:0] hold;
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {hi_o, lo_o}, '0);
    check("R1 reset flags", {62'd0, busy_o, done_o}, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      run(VEC[i][2*W], VEC[i][2*W-1:W], VEC[i][W-1:0], 1'b0);
    end
    for (int i = 0; i < 30; i++) begin
      run(i[0], $urandom, $urandom, 1'b0);
    end

    // R6: inputs ignored while busy
    run(1'b1, 32'hFFFF_FFFD, 32'd2, 1'b1);
    run(1'b0, 32'hCAFE_0001, 32'h8765_4321, 1'b1);

    // R7: result held while idle with no start
    hold = {hi_o, lo_o};
    signed_i = 1'b1; mcand_i = 32'h1111_1111; mplier_i = 32'h2222_2222;
    repeat (5) @(negedge clk);
    check("R7 idle hold", {hi_o, lo_o}, hold);
    check("R7 stays idle", {62'd0, busy_o, done_o}, '0);

    // R1: reset in the middle of an operation
    @(negedge clk);
    start_i = 1'b1; mcand_i = 32'd9; mplier_i = 32'd9;
    @(negedge clk);
    start_i = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async reset outputs", {hi_o, lo_o}, '0);
    check("R1 async reset flags", {62'd0, busy_o, done_o}, '0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run(1'b0, 32'd9, 32'd9, 1'b0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule